// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits between a host that produces a stream of bytes, each with its own 17-bit target address, and a byte-wide parallel EEPROM on an asynchronous bus. The EEPROM has 128-byte pages. Bytes that follow one another in address and stay inside one page are loaded back to back as a single page-write burst. The controller starts a burst with the first accepted byte. It issues one write-enable pulse for each byte. It keeps the idle gap between byte loads below a parameterised limit, so that the device never ends the load phase before the controller means it to.

A burst ends in one of three ways: the next byte belongs to another page, the next byte is not the successor address, or the host stays silent past the gap limit. When the burst ends, the controller releases the data bus and reads back the last byte it wrote, at a fixed read interval, until the value returned matches. A one-cycle status pulse then reports success. If the poll budget runs out first, the pulse reports failure. While the poll runs, the host port accepts nothing. A single isolated byte follows the same path as a burst of one.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `inReady` is 1, `memCeN`, `memOeN` and `memWeN` are 1, `memDriveEn` is 0 and `doneValid` is 0.
- R2: Each accepted byte produces exactly one low pulse on `memWeN` of `WE_PULSE` cycles. Throughout the pulse `memCeN` is 0, `memDriveEn` is 1, `memAddr` carries the byte's address and `memDout` carries its data.
- R3: A byte whose address is the previous byte's address plus one, with the same page bits (address bits 16..7), is accepted into the current burst with no poll in between.
- R4: A byte in a different page, or not at the successor address, ends the current burst. The byte is held off (`inReady` 0) until that burst has reported, and it then starts a new burst.
- R5: If no fitting byte arrives, polling begins (`memOeN` falls) exactly `GAP_LIMIT`+1 cycles after `memWeN` rises at the end of a burst's last byte.
- R6: While `memOeN` is 0, `memDriveEn` is 0, `memWeN` is 1 and `memAddr` equals the address of the burst's last byte.
- R7: When the value on `memDin` equals the last written byte at a read sample, the sample being taken every `READ_WAIT` cycles counted from poll start, `doneValid` pulses for one cycle with `doneError` 0.
- R8: If no sample has matched within `POLL_TIMEOUT` poll cycles, `doneValid` pulses with `doneError` 1.
- R9: A match on the sample that falls in the final timeout cycle counts as success (`doneError` 0).
- R10: `inReady` is 0 during polling and during the status cycle.
- R11: A fitting byte presented in the very cycle in which the gap limit expires is accepted into the current burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Host byte available |
| inReady | output | 1 | Controller accepts the host byte this cycle |
| inAddr | input | 17 | Target byte address |
| inData | input | 8 | Byte to write |
| memAddr | output | 17 | EEPROM address |
| memDout | output | 8 | Data driven toward the EEPROM |
| memDin | input | 8 | Data read from the EEPROM |
| memDriveEn | output | 1 | 1 when the controller drives the data bus |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| doneValid | output | 1 | One-cycle burst completion pulse |
| doneError | output | 1 | With `doneValid`: 1 when polling timed out |

## Verification
Two pairs of events can land in the same cycle. The first is the poll timeout and a successful read-back. The bench's memory model sets its busy time so that the first matching sample is the one in the last timeout cycle, and it expects a clean completion. One cycle more of busy time must yield an error. The second pair is gap expiry and the arrival of a fitting byte. The bench presents the byte in exactly the expiry cycle and expects one burst with one status pulse. One cycle later it expects two bursts.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RECOVER,
    ST_LOAD,
    ST_POLL,
    ST_REPORT
  } pwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch host address and data
    logic weActive;    // time the write-enable pulse
    logic gapActive;   // time the inter-byte gap
    logic pollActive;  // run read-back timers
  } pwStrobe_t;

endpackage

// File: rtl/eeprom_pw_datapath.sv
module eeprom_pw_datapath
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 7,
  parameter int WE_PULSE     = 20,
  parameter int GAP_LIMIT    = 30000,
  parameter int READ_WAIT    = 8,
  parameter int POLL_TIMEOUT = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         strb,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] curData,
  output logic              fits,
  output logic              weDone,
  output logic              gapExpired,
  output logic              pollMatch,
  output logic              pollTimeout
);

  localparam int WE_W   = $clog2(WE_PULSE + 1);
  localparam int GAP_W  = $clog2(GAP_LIMIT + 1);
  localparam int RD_W   = $clog2(READ_WAIT + 1);
  localparam int TIME_W = $clog2(POLL_TIMEOUT + 1);

  logic [WE_W-1:0]      weCnt;
  logic [GAP_W-1:0]     gapCnt;
  logic [RD_W-1:0]      readCnt;
  logic [TIME_W-1:0]    timeCnt;
  logic [PAGE_BITS-1:0] nextOff;
  logic                 sampleNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      curData <= '0;
    end else if (strb.capture) begin
      curAddr <= inAddr;
      curData <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weCnt   <= '0;
      gapCnt  <= '0;
      readCnt <= '0;
      timeCnt <= '0;
    end else begin
      weCnt  <= strb.weActive  ? weCnt + WE_W'(1)   : '0;
      gapCnt <= strb.gapActive ? gapCnt + GAP_W'(1) : '0;
      if (strb.pollActive) begin
        readCnt <= sampleNow ? '0 : readCnt + RD_W'(1);
        timeCnt <= timeCnt + TIME_W'(1);
      end else begin
        readCnt <= '0;
        timeCnt <= '0;
      end
    end
  end

  assign nextOff     = curAddr[PAGE_BITS-1:0] + PAGE_BITS'(1);
  assign fits        = (inAddr[ADDR_W-1:PAGE_BITS] == curAddr[ADDR_W-1:PAGE_BITS])
                     && (curAddr[PAGE_BITS-1:0] != {PAGE_BITS{1'b1}})
                     && (inAddr[PAGE_BITS-1:0] == nextOff);
  assign weDone      = strb.weActive && (weCnt == WE_W'(WE_PULSE - 1));
  assign gapExpired  = strb.gapActive && (gapCnt == GAP_W'(GAP_LIMIT - 1));
  assign sampleNow   = readCnt == RD_W'(READ_WAIT - 1);
  assign pollMatch   = strb.pollActive && sampleNow && (memDin == curData);
  assign pollTimeout = strb.pollActive && (timeCnt == TIME_W'(POLL_TIMEOUT - 1));

  // a byte merged into a running burst never leaves its page
  p_same_page_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.gapActive) |=>
      (curAddr[ADDR_W-1:PAGE_BITS] == $past(curAddr[ADDR_W-1:PAGE_BITS])))
    else $error("burst crossed a page");

endmodule

// File: rtl/eeprom_pw_ctrl.sv
module eeprom_pw_ctrl
  import eeprom_pw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      fits,
  input  logic      weDone,
  input  logic      gapExpired,
  input  logic      pollMatch,
  input  logic      pollTimeout,
  output pwStrobe_t strb,
  output logic      inReady,
  output logic      memDriveEn,
  output logic      memCeN,
  output logic      memOeN,
  output logic      memWeN,
  output logic      doneValid,
  output logic      doneError
);

  pwState_t state, nextState;
  logic     errNext;

  always_comb begin
    nextState = state;
    strb      = '0;
    inReady   = 1'b0;
    errNext   = doneError;
    unique case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.capture = 1'b1;
          nextState    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strb.weActive = 1'b1;
        if (weDone) nextState = ST_RECOVER;
      end
      ST_RECOVER: nextState = ST_LOAD;
      ST_LOAD: begin
        strb.gapActive = 1'b1;
        inReady        = fits;
        if (inValid && fits) begin
          strb.capture = 1'b1;
          nextState    = ST_WRITE;
        end else if (inValid || gapExpired) begin
          nextState = ST_POLL;
        end
      end
      ST_POLL: begin
        strb.pollActive = 1'b1;
        if (pollMatch) begin
          errNext   = 1'b0;
          nextState = ST_REPORT;
        end else if (pollTimeout) begin
          errNext   = 1'b1;
          nextState = ST_REPORT;
        end
      end
      ST_REPORT: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneError <= 1'b0;
    end else begin
      state     <= nextState;
      doneError <= errNext;
    end
  end

  assign doneValid  = state == ST_REPORT;
  assign memWeN     = state != ST_WRITE;
  assign memOeN     = state != ST_POLL;
  assign memCeN     = !(state == ST_WRITE || state == ST_RECOVER || state == ST_POLL);
  assign memDriveEn = state == ST_WRITE || state == ST_RECOVER || state == ST_LOAD;

  p_bus_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memDriveEn && memWeN))
    else $error("bus driven during read-back");

  p_no_accept_poll_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !inReady)
    else $error("host accepted during poll");

  p_gap_close_r5: assert property (@(posedge clk) disable iff (!rstN)
    (gapExpired && !inValid) |=> !memOeN)
    else $error("gap expiry did not start polling");

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid)
    else $error("status pulse longer than a cycle");

  p_match_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    pollMatch |=> (doneValid && !doneError))
    else $error("match not reported as success");

  p_timeout_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pollTimeout && !pollMatch) |=> (doneValid && doneError))
    else $error("timeout not reported");

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 7,
  parameter int WE_PULSE     = 20,
  parameter int GAP_LIMIT    = 30000,
  parameter int READ_WAIT    = 8,
  parameter int POLL_TIMEOUT = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDriveEn,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              doneValid,
  output logic              doneError
);

  pwStrobe_t strb;
  logic      fits, weDone, gapExpired, pollMatch, pollTimeout;

  eeprom_pw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fits(fits), .weDone(weDone),
    .gapExpired(gapExpired), .pollMatch(pollMatch), .pollTimeout(pollTimeout),
    .strb(strb), .inReady(inReady), .memDriveEn(memDriveEn), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .doneValid(doneValid), .doneError(doneError)
  );

  eeprom_pw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .WE_PULSE(WE_PULSE),
    .GAP_LIMIT(GAP_LIMIT), .READ_WAIT(READ_WAIT), .POLL_TIMEOUT(POLL_TIMEOUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inAddr(inAddr), .inData(inData),
    .memDin(memDin), .curAddr(memAddr), .curData(memDout), .fits(fits),
    .weDone(weDone), .gapExpired(gapExpired), .pollMatch(pollMatch),
    .pollTimeout(pollTimeout)
  );

endmodule

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/100ps
module eeprom_page_writer_bench;

  localparam int WE_P = 3;
  localparam int GAP  = 20;
  localparam int RDW  = 4;
  localparam int TOUT = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [16:0] inAddr = '0;
  logic [7:0]  inData = '0;
  logic [16:0] memAddr;
  logic [7:0]  memDout, memDin;
  logic        memDriveEn, memCeN, memOeN, memWeN, doneValid, doneError;

  always #2 clk = ~clk;

  eeprom_page_writer #(.WE_PULSE(WE_P), .GAP_LIMIT(GAP), .READ_WAIT(RDW),
                       .POLL_TIMEOUT(TOUT)) u_eeprom_page_writer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .inData(inData), .memAddr(memAddr), .memDout(memDout), .memDin(memDin),
    .memDriveEn(memDriveEn), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .doneValid(doneValid), .doneError(doneError)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: reads return inverted data until busyCycles poll cycles pass
  logic [7:0] lastData = '0;
  int         oeCnt = 0;
  int         busyCycles = 5;
  assign memDin = (oeCnt >= busyCycles) ? lastData : ~lastData;
  always @(posedge clk) begin
    if (!memWeN) begin
      lastData <= memDout;
      oeCnt    <= 0;
    end else if (!memOeN) oeCnt <= oeCnt + 1;
  end

  // scoreboard
  logic [24:0] wrQ[$];
  logic        doneQ[$];

  int          cyc = 0, weRises = 0, weRiseCyc = 0, weLowLen = 0;
  logic        prevWe = 1'b1, prevOe = 1'b1, gapArmed = 1'b0;
  logic [16:0] lastWrAddr = '0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!memWeN) begin
        weLowLen++;
        if (!memCeN && memDriveEn && wrQ.size() > 0)
          check("R2 addr/data held", {memAddr, memDout}, wrQ[0]);
        else check("R2 strobes in pulse", {memCeN, memDriveEn, 1'(wrQ.size() > 0)}, 3'b011);
      end
      if (!prevWe && memWeN) begin
        weRises++;
        weRiseCyc = cyc;
        check("R2 pulse width", weLowLen, WE_P);
        if (wrQ.size() > 0) begin
          lastWrAddr = wrQ[0][24:8];
          void'(wrQ.pop_front());
        end
      end
      if (memWeN) weLowLen = 0;
      if (prevOe && !memOeN) begin
        check("R6 released/addr", {memDriveEn, memWeN, memAddr}, {1'b0, 1'b1, lastWrAddr});
        check("R10 ready low in poll", inReady, 1'b0);
        if (gapArmed) begin
          check("R5 gap to poll", cyc - weRiseCyc, GAP + 1);
          gapArmed = 1'b0;
        end
      end
      if (doneValid) begin
        check("R10 ready low in report", inReady, 1'b0);
        if (doneQ.size() == 0) check("R7 unexpected done", 1, 0);
        else check("R7/R8/R9 done status", doneError, doneQ.pop_front());
      end
    end
    prevWe = memWeN;
    prevOe = memOeN;
  end

  // driver
  task automatic sendByte(input logic [16:0] a, input logic [7:0] d);
    wrQ.push_back({a, d});
    inAddr  = a;
    inData  = d;
    inValid = 1'b1;
    forever begin
      #1;
      if (inReady) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic waitDrained();
    while (doneQ.size() > 0 || wrQ.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic waitWeRise();
    int old = weRises;
    while (weRises == old) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {inReady, memCeN, memOeN, memWeN, memDriveEn, doneValid},
          6'b111100);
    rstN = 1'b1;
    @(negedge clk);

    // R5/R7: single byte, gap timing, quick match
    busyCycles = 5;
    doneQ.push_back(1'b0);
    gapArmed = 1'b1;
    sendByte(17'h00010, 8'hA5);
    waitDrained();

    // R3: three sequential bytes in one burst
    doneQ.push_back(1'b0);
    sendByte(17'h00200, 8'h11);
    sendByte(17'h00201, 8'h22);
    sendByte(17'h00202, 8'h33);
    waitDrained();

    // R4: page crossing splits into two bursts
    doneQ.push_back(1'b0);
    doneQ.push_back(1'b0);
    sendByte(17'h0007E, 8'h44);
    sendByte(17'h0007F, 8'h55);
    sendByte(17'h00080, 8'h66);
    waitDrained();

    // R4: non-sequential address in same page
    doneQ.push_back(1'b0);
    doneQ.push_back(1'b0);
    sendByte(17'h00300, 8'h77);
    sendByte(17'h00305, 8'h88);
    waitDrained();

    // R4: top address then address zero
    doneQ.push_back(1'b0);
    doneQ.push_back(1'b0);
    sendByte(17'h1FFFF, 8'h99);
    sendByte(17'h00000, 8'hAA);
    waitDrained();

    // R11: fitting byte in the expiry cycle joins the burst
    doneQ.push_back(1'b0);
    sendByte(17'h00400, 8'hBB);
    waitWeRise();
    repeat (GAP) @(negedge clk);
    sendByte(17'h00401, 8'hCC);
    waitDrained();

    // R5: one cycle later it starts a new burst
    doneQ.push_back(1'b0);
    doneQ.push_back(1'b0);
    sendByte(17'h00500, 8'hDD);
    waitWeRise();
    repeat (GAP + 1) @(negedge clk);
    sendByte(17'h00501, 8'hEE);
    waitDrained();

    // R9: match on the last timeout sample is success
    busyCycles = TOUT - 1;
    doneQ.push_back(1'b0);
    sendByte(17'h00600, 8'h5A);
    waitDrained();

    // R8: one cycle more gives a timeout error
    busyCycles = TOUT;
    doneQ.push_back(1'b1);
    sendByte(17'h00700, 8'hC3);
    waitDrained();

    check("R7 all expected done seen", doneQ.size(), 0);
    check("R2 all writes seen", wrQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule